// File: doc/BRIEF.md
# PWM Generator with Committed Setting Updates

This block produces one pulse-width-modulated output from a phase accumulator. Its rate (base unit) and duty threshold (on-time divisor) are written by software into a single control word. A write only lands in shadow storage. The running generator picks up new values only when software raises a self-clearing commit bit. The hardware holds that bit high for a fixed number of clocks, copies the shadow values into the active generator, and drops the bit on the same edge. Software can therefore poll the bit as a busy flag.

The enable bit and the commit bit live in the same word. Software commonly sets enable by reading the word and writing it back with one bit changed. If that read lands while a commit is still in progress, the write-back carries a 1 in the commit bit. The block folds such a write into the transfer already in progress, so the bit cannot get stuck. Writing a 0 to the commit bit never cancels a transfer in progress.

While enabled, the accumulator adds the base unit on every clock. The output is high whenever the top 8 accumulator bits are below the duty threshold. While disabled, the output is low and the accumulator rests at zero.

Top module: `pwm_shadow_unit`

## Requirements
- R1: After synchronous active-low reset, the read word is all zero and `pwm_out` is low.
- R2: The control word layout is as follows: base unit in bits [15:0], duty threshold in bits [23:16], commit bit 24, enable bit 25. A read returns the shadow base and duty together with the live commit and enable bits.
- R3: A write with the commit bit at 0 changes only the shadow fields and the enable bit. It leaves the running waveform's settings untouched.
- R4: A write that sets the commit bit while it reads 0 makes the bit read 1 for exactly DELAY_CYCLES (default 4) clocks. The bit then reads 0. The active settings are loaded on the edge where the bit clears.
- R5: A write that sets the commit bit while it already reads 1 neither restarts nor extends the delay. The bit clears on the original schedule and never stays high longer than DELAY_CYCLES clocks.
- R6: A write with the commit bit at 0 while a commit is in progress does not cancel it. The bit still clears on schedule and the transfer still happens.
- R7: While enabled, a commit switches the running output to the new settings without any change to the enable bit.
- R8: With enable at 0, the output is low and the accumulator is held at zero. After enable rises, the accumulator starts at zero. With base 256 and duty 64, the output is high for exactly the first 64 clocks and low for the next 192.
- R9: While enabled, the output is high exactly when the top 8 accumulator bits are below the duty threshold. With base 256, any 256 consecutive clocks contain exactly as many high clocks as the duty value. This includes 0 and 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 26 | Control word to write |
| rd_data | output | 26 | Shadow fields plus live commit and enable bits |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench mimics the read-modify-write race. It writes the commit bit again one clock after setting it, and expects the bit to clear on the first request's schedule. A design that restarted the delay would clear late, and one that latched the second request would never clear at all. It also writes a 0 into the commit bit while a transfer is in progress. A design that let that cancel the transfer would keep the old duty, which the bench sees by counting high clocks over a full period. Other directed cases cover the following:
- a shadow-only write while running, which a design that bypassed the shadow stage would show as an early duty change;
- a restart after disable, which must begin from phase zero;
- the duty extremes 0 and 255, which catch an off-by-one in the compare.

// File: rtl/pwm_shadow_pkg.sv
// Shared definitions for the shadowed PWM block.
// Assumes an 8-bit duty threshold compared against the accumulator top bits.
package pwm_shadow_pkg;
    localparam int DUTY_W = 8;
    typedef logic [DUTY_W-1:0] duty_t;

    // Width of the control word for a given base-unit width.
    function automatic int word_width(input int base_w);
        return base_w + DUTY_W + 2;
    endfunction
endpackage

// File: rtl/pwm_ctrl_regs.sv
// Control word register file: shadow base unit, shadow duty, enable bit.
// Produces a one-cycle commit request when a write carries the commit bit.
// Assumes field order base | duty | commit | enable from LSB upward.
module pwm_ctrl_regs
    import pwm_shadow_pkg::*;
#(
    parameter int BASE_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [word_width(BASE_W)-1:0] wr_data,
    output logic [BASE_W-1:0]            shadow_base,
    output duty_t                        shadow_duty,
    output logic                         enable,
    output logic                         commit_req
);
    localparam int DUTY_LSB   = BASE_W;
    localparam int COMMIT_BIT = BASE_W + DUTY_W;
    localparam int ENABLE_BIT = BASE_W + DUTY_W + 1;

    // Capture the shadow fields and the enable bit on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_base <= '0;
            shadow_duty <= '0;
            enable      <= 1'b0;
        end else if (wr_en) begin
            shadow_base <= wr_data[BASE_W-1:0];
            shadow_duty <= wr_data[DUTY_LSB +: DUTY_W];
            enable      <= wr_data[ENABLE_BIT];
        end
    end

    // Flag a write that asks for a commit.
    always_comb begin
        commit_req = wr_en && wr_data[COMMIT_BIT];
    end

    // R2
    shadow_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (shadow_base == $past(wr_data[BASE_W-1:0])
                   && shadow_duty == $past(wr_data[DUTY_LSB +: DUTY_W])));
endmodule

// File: rtl/pwm_commit_seq.sv
// Commit sequencer: holds the busy (commit) bit for DELAY_CYCLES clocks,
// then issues a one-cycle commit strobe on the edge where busy clears.
// A request arriving while busy merges into the pending commit.
// Assumes DELAY_CYCLES >= 1.
module pwm_commit_seq #(
    parameter int DELAY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit_req,
    output logic busy,
    output logic commit
);
    localparam int CNT_W = (DELAY_CYCLES < 2) ? 1 : $clog2(DELAY_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

    logic [CNT_W-1:0] wait_cnt;

    // The transfer fires on the final cycle of the busy window.
    always_comb begin
        commit = busy && (wait_cnt == LAST);
    end

    // Arm on a request while idle, count while busy, and release at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            wait_cnt <= '0;
        end else if (!busy) begin
            busy     <= commit_req;
            wait_cnt <= '0;
        end else if (commit) begin
            busy     <= 1'b0;
            wait_cnt <= '0;
        end else begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    // Independent length tracker for the busy window.
    localparam int RUN_W = $clog2(DELAY_CYCLES + 2) + 1;
    logic [RUN_W-1:0] busy_run;

    // Count consecutive busy cycles for the bound check.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_run <= '0;
        else if (!busy) busy_run <= '0;
        else if (busy_run != {RUN_W{1'b1}}) busy_run <= busy_run + 1'b1;
    end

    // R5
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < RUN_W'(DELAY_CYCLES)));
    // R6
    no_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit) |=> busy);
    // R4
    commit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);
endmodule

// File: rtl/pwm_phase_gen.sv
// Waveform engine: active base and duty registers loaded on commit,
// a phase accumulator stepping by the base unit, and the duty compare.
// Assumes BASE_W >= 8. The accumulator rests at zero while disabled.
module pwm_phase_gen
    import pwm_shadow_pkg::*;
#(
    parameter int BASE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              commit,
    input  logic [BASE_W-1:0] shadow_base,
    input  duty_t             shadow_duty,
    output logic              pwm_out
);
    localparam int TOP_LSB = BASE_W - DUTY_W;

    logic [BASE_W-1:0] act_base;
    duty_t             act_duty;
    logic [BASE_W-1:0] phase_acc;
    duty_t             phase_top;

    // Copy the shadow settings into the active set on a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_base <= '0;
            act_duty <= '0;
        end else if (commit) begin
            act_base <= shadow_base;
            act_duty <= shadow_duty;
        end
    end

    // Advance the phase while enabled, and park it at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) phase_acc <= '0;
        else                   phase_acc <= phase_acc + act_base;
    end

    // Drive the output high while the phase top is below the duty threshold.
    always_comb begin
        phase_top = phase_acc[TOP_LSB +: DUTY_W];
        pwm_out   = enable && (phase_top < act_duty);
    end

    // R8
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |-> (phase_acc == '0));
    // R7
    transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (act_base == $past(shadow_base) && act_duty == $past(shadow_duty)));
    // R3
    hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(act_base) && $stable(act_duty)));
endmodule

// File: rtl/pwm_shadow_unit.sv
// Top level of the shadowed PWM: register file, commit sequencer and waveform
// engine. The read word reflects the shadow fields and the live commit and enable bits.
// Assumes a single clock domain and synchronous active-low reset.
module pwm_shadow_unit
    import pwm_shadow_pkg::*;
#(
    parameter int BASE_W       = 16,
    parameter int DELAY_CYCLES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [word_width(BASE_W)-1:0] wr_data,
    output logic [word_width(BASE_W)-1:0] rd_data,
    output logic                          pwm_out
);
    logic [BASE_W-1:0] shadow_base;
    duty_t             shadow_duty;
    logic              enable;
    logic              commit_req;
    logic              busy;
    logic              commit;

    pwm_ctrl_regs #(.BASE_W(BASE_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .shadow_base (shadow_base),
        .shadow_duty (shadow_duty),
        .enable      (enable),
        .commit_req  (commit_req)
    );

    pwm_commit_seq #(.DELAY_CYCLES(DELAY_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_req (commit_req),
        .busy       (busy),
        .commit     (commit)
    );

    pwm_phase_gen #(.BASE_W(BASE_W)) u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .commit      (commit),
        .shadow_base (shadow_base),
        .shadow_duty (shadow_duty),
        .pwm_out     (pwm_out)
    );

    // Assemble the read word from the shadow fields and the live status bits.
    always_comb begin
        rd_data = {enable, busy, shadow_duty, shadow_base};
    end

    // R8
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !pwm_out);
endmodule

// File: tb/pwm_shadow_unit_test.sv
`timescale 1ns/1ps
module pwm_shadow_unit_test;
    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [25:0] wr_data;
    logic [25:0] rd_data;
    logic        pwm_out;

    int checks = 0;
    int fails  = 0;

    pwm_shadow_unit #(.BASE_W(16), .DELAY_CYCLES(D)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pwm_out(pwm_out)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    function automatic logic [25:0] mk(input logic [15:0] b, input logic [7:0] d,
                                       input logic upd, input logic en);
        return {en, upd, d, b};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge; returns at the following negedge.
    task automatic wr(input logic [25:0] w);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_high(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) c++;
            @(negedge clk);
        end
    endtask

    task automatic t_layout;
        wr(mk(16'h1234, 8'h5A, 1'b0, 1'b0));
        chk("R2 read layout", 32'(rd_data), 32'h005A1234);
        chk("R3 no output from shadow write", 32'(pwm_out), 0);
    endtask

    task automatic t_first_activation;
        int c;
        wr(mk(16'd256, 8'd64, 1'b1, 1'b0));
        for (int i = 0; i < D; i++) begin
            chk("R4 commit bit busy", 32'(rd_data[24]), 1);
            @(negedge clk);
        end
        chk("R4 commit bit cleared", 32'(rd_data[24]), 0);
        chk("R8 low while disabled", 32'(pwm_out), 0);
        wr(mk(16'd256, 8'd64, 1'b0, 1'b1));
        count_high(256, c);
        chk("R9 duty 64 count", 32'(c), 64);
    endtask

    task automatic t_shadow_hold;
        int c;
        wr(mk(16'd256, 8'd200, 1'b0, 1'b1));
        chk("R2 shadow duty readback", 32'(rd_data[23:16]), 200);
        count_high(256, c);
        chk("R3 running duty unchanged", 32'(c), 64);
    endtask

    task automatic t_live_update;
        int c;
        wr(mk(16'd256, 8'd200, 1'b1, 1'b1));
        repeat (D) @(negedge clk);
        chk("R4 commit bit cleared", 32'(rd_data[24]), 0);
        chk("R7 enable kept", 32'(rd_data[25]), 1);
        count_high(256, c);
        chk("R7 new duty applied", 32'(c), 200);
    endtask

    task automatic t_double_set;
        int c;
        wr(mk(16'd4096, 8'd80, 1'b1, 1'b1));
        wr(mk(16'd4096, 8'd80, 1'b1, 1'b1));
        for (int i = 0; i < D - 1; i++) begin
            chk("R5 still busy", 32'(rd_data[24]), 1);
            @(negedge clk);
        end
        chk("R5 clears on original schedule", 32'(rd_data[24]), 0);
        count_high(16, c);
        chk("R5 transfer done", 32'(c), 5);
    endtask

    task automatic t_no_cancel;
        int c;
        wr(mk(16'd256, 8'd128, 1'b1, 1'b1));
        wr(mk(16'd256, 8'd128, 1'b0, 1'b1));
        for (int i = 0; i < D - 1; i++) begin
            chk("R6 not cancelled", 32'(rd_data[24]), 1);
            @(negedge clk);
        end
        chk("R6 cleared", 32'(rd_data[24]), 0);
        count_high(256, c);
        chk("R6 transfer kept", 32'(c), 128);
    endtask

    task automatic t_restart;
        int c;
        int first;
        int rest;
        wr(mk(16'd256, 8'd128, 1'b0, 1'b0));
        count_high(20, c);
        chk("R8 low when disabled", 32'(c), 0);
        wr(mk(16'd256, 8'd64, 1'b1, 1'b0));
        count_high(D, c);
        chk("R8 low during commit while disabled", 32'(c), 0);
        wr(mk(16'd256, 8'd64, 1'b0, 1'b1));
        count_high(64, first);
        count_high(192, rest);
        chk("R8 restart high span", 32'(first), 64);
        chk("R8 restart low span", 32'(rest), 0);
    endtask

    task automatic t_extremes;
        int c;
        wr(mk(16'd256, 8'd0, 1'b1, 1'b1));
        repeat (D) @(negedge clk);
        count_high(256, c);
        chk("R9 duty 0", 32'(c), 0);
        wr(mk(16'd256, 8'd255, 1'b1, 1'b1));
        repeat (D) @(negedge clk);
        count_high(256, c);
        chk("R9 duty 255", 32'(c), 255);
    endtask

    initial begin
        rst_n = 1'b0;
        wr_en = 1'b0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset read", 32'(rd_data), 0);
        chk("R1 reset output", 32'(pwm_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 32'(rd_data), 0);
        t_layout();
        t_first_activation();
        t_shadow_hold();
        t_live_update();
        t_double_set();
        t_no_cancel();
        t_restart();
        t_extremes();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule